// File: doc/BRIEF.md
# Serial-Bus Byte Memory Device

This block is the device side of a serial byte memory reached over an SPI-style four-wire link. The host drives a select line (active low), a serial clock, a pause line (active low) and a serial data input; the block answers on a serial data output. Every transaction starts with an 8-bit command. Array reads and writes then take a 16-bit address. A read streams bytes out of an internal byte array for as long as the host keeps clocking. A write stores received bytes, and the address advances inside a 128-byte page.

A small status byte holds a write-enable latch (bit 1) and a two-bit protect code (bits 3:2). Together they decide which array bytes a write may change. The protect code closes the top quarter, the top half or the whole array. The serial lines are brought into the system clock domain through two-flop synchronizers. The system clock must run at least four times faster than the serial clock. Depth and page size are parameters.

Top module: `spi_mem_slave`

## Requirements
- R1: Data-in is sampled on each rising edge of the serial clock, most significant bit first. An edge counts only while select is low and pause is high. Clock edges seen while select is high change nothing.
- R2: When select goes high with pause high, the transaction ends. Data-out goes to 1 and the next transaction starts with a fresh 8-bit command.
- R3: While pause is low, clock edges and select changes are ignored. A transaction resumes where it stopped once pause returns high.
- R4: Command 0x06 sets the write-enable latch and command 0x04 clears it. Command 0x05 returns the status byte, which holds the latch in bit 1, the protect code in bits 3:2 and zeros elsewhere. The status byte is sent again for as long as clocking continues.
- R5: Command 0x01 followed by one byte copies only bits 3:2 of that byte into the protect code and keeps the latch. Later bits in the same transaction are ignored.
- R6: Any other command leaves data-out at 1 for the rest of the transaction and changes no state.
- R7: Command 0x03 plus a 16-bit address streams array bytes MSB first, one bit per rising edge, starting with the first edge after the address. Address bits above the array size are dropped. The address rises by one after each byte and wraps from the last byte to byte 0.
- R8: Command 0x02 plus a 16-bit address stores each following byte. After each byte only the low 7 address bits advance, so bytes wrap within a 128-byte page.
- R9: An array byte is not stored while the write-enable latch is clear.
- R10: With the latch set, protect code 1 blocks writes to the top quarter of the array, code 2 blocks the top half, code 3 blocks everything and code 0 blocks nothing.
- R11: After reset the status byte is 0x00, data-out is 1 and the block waits for a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_sel_n | input | 1 | Transaction select, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_hold_n | input | 1 | Pause, active low |
| ser_din | input | 1 | Serial data from the host |
| ser_dout | output | 1 | Serial data to the host, idles high |

## Verification
The bench fills a reduced 512-byte array through garbage-laden addresses and reads it back in one stream that crosses the end of the array. A design that kept high address bits, or stopped at the end, would return wrong bytes there. A page-end write checks that the address wraps to the page start. A design that carried into the next page would overwrite byte 0x080 and leave byte 0x000 untouched. Every protect code is tried against one address in each quarter, with the latch clear and with it set. Pauses inside a transaction, where the host toggles both the clock and select, must leave no trace. Partial commands cut short by select, and unknown commands, must leave the status byte untouched and data-out high.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_WDATA,
    ST_FETCH,
    ST_LOAD,
    ST_READ,
    ST_IDLE
  } mem_state_e;

  localparam logic [7:0] OP_STAT_WR  = 8'h01;
  localparam logic [7:0] OP_ARR_WR   = 8'h02;
  localparam logic [7:0] OP_ARR_RD   = 8'h03;
  localparam logic [7:0] OP_LATCH_CL = 8'h04;
  localparam logic [7:0] OP_STAT_RD  = 8'h05;
  localparam logic [7:0] OP_LATCH_ST = 8'h06;

  // Status byte layout: protect code in [3:2], write latch in [1].
  function automatic logic [7:0] status_byte(input logic wel, input logic [1:0] bp);
    return {4'b0000, bp, wel, 1'b0};
  endfunction

endpackage

// File: rtl/spi_line_sync.sv
module spi_line_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  output logic [W-1:1] lvl_o,
  output logic         rise_o
);

  logic [W-1:0] stage1_q, stage2_q;
  logic         prev_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1_q[i] <= RST_VAL[i];
        stage2_q[i] <= RST_VAL[i];
      end else begin
        stage1_q[i] <= raw_i[i];
        stage2_q[i] <= stage1_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL[0];
    else        prev_q <= stage2_q[0];
  end

  assign rise_o = stage2_q[0] & ~prev_q;
  assign lvl_o  = stage2_q[W-1:1];

  // R1
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> !rise_o);

endmodule

// File: rtl/spi_byte_ram.sv
module spi_byte_ram #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
  import spi_mem_pkg::*;
#(
  parameter int ADDR_BITS = 16,
  parameter int MEM_AW    = 11,
  parameter int PAGE_AW   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_sel_n,
  input  logic ser_clk,
  input  logic ser_hold_n,
  input  logic ser_din,
  output logic ser_dout
);

  localparam int CNT_W = $clog2(ADDR_BITS + 1);
  localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(7);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_BITS - 1);

  // Advance only the in-page part of the address.
  function automatic logic [MEM_AW-1:0] page_step(input logic [MEM_AW-1:0] a);
    logic [MEM_AW-1:0] r;
    r = a;
    r[PAGE_AW-1:0] = a[PAGE_AW-1:0] + 1'b1;
    return r;
  endfunction

  // Protect code to blocked region: top quarter, top half, all, none.
  function automatic logic locked(input logic [1:0] bp, input logic [MEM_AW-1:0] a);
    case (bp)
      2'd1:    return &a[MEM_AW-1 -: 2];
      2'd2:    return a[MEM_AW-1];
      2'd3:    return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Synchronized lines: [3]=din, [2]=hold_n, [1]=sel_n, [0]=clk.
  logic [3:1] lvl;
  logic       rise;

  spi_line_sync #(.W(4), .RST_VAL(4'b0110)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({ser_din, ser_hold_n, ser_sel_n, ser_clk}),
    .lvl_o  (lvl),
    .rise_o (rise)
  );

  logic din_s, hold_s, sel_s;
  assign din_s  = lvl[3];
  assign hold_s = lvl[2];
  assign sel_s  = lvl[1];

  // Named internal events.
  logic live, sel_end, bit_evt;
  assign live    = hold_s;
  assign sel_end = hold_s & sel_s;
  assign bit_evt = hold_s & ~sel_s & rise;

  mem_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [7:0]        opc_q, opc_d;
  logic [MEM_AW-1:0] addr_q, addr_d;
  logic [7:0]        sh_q, sh_d;
  logic [7:0]        obuf_q, obuf_d;
  logic              wel_q, wel_d;
  logic [1:0]        bp_q, bp_d;
  logic              dout_q, dout_d;
  logic              ram_we;
  logic [7:0]        ram_q;

  logic [7:0]        opc_shift, byte_shift;
  logic [MEM_AW-1:0] addr_shift;
  assign opc_shift  = {opc_q[6:0], din_s};
  assign byte_shift = {sh_q[6:0], din_s};
  assign addr_shift = {addr_q[MEM_AW-2:0], din_s};

  spi_byte_ram #(.AW(MEM_AW)) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (addr_q),
    .wdata_i (byte_shift),
    .raddr_i (addr_q),
    .rdata_o (ram_q)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opc_d   = opc_q;
    addr_d  = addr_q;
    sh_d    = sh_q;
    obuf_d  = obuf_q;
    wel_d   = wel_q;
    bp_d    = bp_q;
    dout_d  = dout_q;
    ram_we  = 1'b0;
    if (sel_end) begin
      state_d = ST_OPC;
      cnt_d   = '0;
      opc_d   = '0;
      dout_d  = 1'b1;
    end else if (live) begin
      case (state_q)
        ST_OPC: if (bit_evt) begin
          opc_d = opc_shift;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            case (opc_shift)
              OP_STAT_WR:            begin sh_d = '0; state_d = ST_WDATA; end
              OP_ARR_WR, OP_ARR_RD:  state_d = ST_ADDR;
              OP_LATCH_CL:           begin wel_d = 1'b0; state_d = ST_IDLE; end
              OP_STAT_RD:            begin obuf_d = status_byte(wel_q, bp_q); state_d = ST_READ; end
              OP_LATCH_ST:           begin wel_d = 1'b1; state_d = ST_IDLE; end
              default:               state_d = ST_IDLE;
            endcase
          end
        end
        ST_ADDR: if (bit_evt) begin
          addr_d = addr_shift;
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == ADDR_LAST) begin
            cnt_d   = '0;
            sh_d    = '0;
            state_d = opc_q[0] ? ST_FETCH : ST_WDATA;
          end
        end
        ST_WDATA: if (bit_evt) begin
          sh_d  = byte_shift;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            sh_d  = '0;
            if (opc_q[0]) begin
              bp_d    = byte_shift[3:2];
              state_d = ST_IDLE;
            end else begin
              ram_we = wel_q && !locked(bp_q, addr_q);
              addr_d = page_step(addr_q);
            end
          end
        end
        ST_FETCH: state_d = ST_LOAD;
        ST_LOAD: begin
          obuf_d  = ram_q;
          state_d = ST_READ;
        end
        ST_READ: if (bit_evt) begin
          dout_d = obuf_q[3'd7 - cnt_q[2:0]];
          cnt_d  = cnt_q + 1'b1;
          if (cnt_q == BYTE_LAST) begin
            cnt_d = '0;
            if (opc_q == OP_ARR_RD) begin
              addr_d  = addr_q + 1'b1;
              state_d = ST_FETCH;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC;
      cnt_q   <= '0;
      opc_q   <= '0;
      addr_q  <= '0;
      sh_q    <= '0;
      obuf_q  <= '0;
      wel_q   <= 1'b0;
      bp_q    <= 2'b00;
      dout_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      sh_q    <= sh_d;
      obuf_q  <= obuf_d;
      wel_q   <= wel_d;
      bp_q    <= bp_d;
      dout_q  <= dout_d;
    end
  end

  assign ser_dout = dout_q;

  // R2
  end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_end |=> (dout_q && state_q == ST_OPC && cnt_q == '0));

  // R2
  opc_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPC) |-> dout_q);

  // R3
  pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> ($stable(state_q) && $stable(cnt_q)));

  // R5
  protect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bp_q) |-> ($past(state_q) == ST_WDATA));

  // R1
  byte_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OPC || state_q == ST_WDATA || state_q == ST_READ) |-> (cnt_q < CNT_W'(8)));

endmodule

// File: tb/sim_spi_mem_slave.sv
module sim_spi_mem_slave;

  localparam int MEM_AW = 9;
  localparam int DEPTH  = 1 << MEM_AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_sel_n = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_hold_n = 1'b1;
  logic ser_din = 1'b0;
  logic ser_dout;

  always #4 clk = ~clk;

  spi_mem_slave #(.ADDR_BITS(16), .MEM_AW(MEM_AW), .PAGE_AW(7)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_sel_n(ser_sel_n), .ser_clk(ser_clk),
    .ser_hold_n(ser_hold_n), .ser_din(ser_din), .ser_dout(ser_dout)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] mdl [DEPTH];
  bit m_wel = 1'b0;
  int m_bp = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] gen(input int seed, input int i);
    return 8'((i * 37 + seed * 11) ^ (i >> 3));
  endfunction

  function automatic bit blocked(input int bp, input int a);
    return (bp == 3) || (bp == 2 && a >= DEPTH / 2) || (bp == 1 && a >= 3 * DEPTH / 4);
  endfunction

  function automatic logic [7:0] m_status();
    return 8'((m_bp << 2) | (m_wel ? 2 : 0));
  endfunction

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbit(input logic b, output logic r);
    ser_din = b;
    wait_n(4);
    ser_clk = 1'b1;
    wait_n(4);
    r = ser_dout;
    ser_clk = 1'b0;
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      logic r;
      xbit(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic sel_on();
    ser_sel_n = 1'b0;
    wait_n(4);
  endtask

  task automatic sel_off();
    wait_n(2);
    ser_sel_n = 1'b1;
    wait_n(5);
  endtask

  task automatic cmd(input logic [7:0] op);
    logic [7:0] rx;
    sel_on();
    xbyte(op, rx);
    sel_off();
  endtask

  task automatic set_latch(input bit v);
    cmd(v ? 8'h06 : 8'h04);
    m_wel = v;
  endtask

  task automatic stat_check(input string tag, input int reps);
    logic [7:0] rx;
    sel_on();
    xbyte(8'h05, rx);
    for (int k = 0; k < reps; k++) begin
      xbyte(8'h00, rx);
      check(tag, rx, m_status());
    end
    sel_off();
  endtask

  task automatic stat_write(input logic [7:0] v);
    logic [7:0] rx;
    sel_on();
    xbyte(8'h01, rx);
    xbyte(v, rx);
    xbyte(8'hFF, rx);
    sel_off();
    m_bp = int'(v[3:2]);
  endtask

  task automatic arr_write(input logic [15:0] a16, input int n, input int seed);
    logic [7:0] rx;
    int a;
    a = int'(a16) % DEPTH;
    sel_on();
    xbyte(8'h02, rx);
    xbyte(a16[15:8], rx);
    xbyte(a16[7:0], rx);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = gen(seed, i);
      xbyte(d, rx);
      if (m_wel && !blocked(m_bp, a)) mdl[a] = d;
      a = (a & ~127) | ((a + 1) & 127);
    end
    sel_off();
  endtask

  task automatic arr_check(input string tag, input logic [15:0] a16, input int n);
    logic [7:0] rx;
    sel_on();
    xbyte(8'h03, rx);
    xbyte(a16[15:8], rx);
    xbyte(a16[7:0], rx);
    for (int i = 0; i < n; i++) begin
      xbyte(8'h00, rx);
      check(tag, rx, mdl[(int'(a16) + i) % DEPTH]);
    end
    sel_off();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic r;
    wait_n(5);
    rst_n = 1'b1;
    wait_n(4);

    // R11: reset state
    check("R11 dout after reset", ser_dout, 1'b1);
    stat_check("R11 status after reset", 1);

    // R1: clock edges with select high are ignored
    for (int i = 0; i < 5; i++) xbit(1'b1, r);
    check("R1 dout with select high", r, 1'b1);
    stat_check("R1 status after stray clocks", 1);

    // R4: latch set/clear and repeated status
    set_latch(1'b1);
    stat_check("R4 latch set, repeated status", 3);
    set_latch(1'b0);
    stat_check("R4 latch cleared", 1);

    // R5: status write changes only protect bits
    stat_write(8'hF3);
    stat_check("R5 status write keeps latch clear", 1);
    set_latch(1'b1);
    stat_write(8'hFF);
    stat_check("R5 protect bits set, latch kept", 1);
    stat_write(8'hF3);
    stat_check("R5 protect bits cleared", 1);

    // R7/R8: fill the whole array, high address bits are junk
    for (int p = 0; p < DEPTH / 128; p++)
      arr_write(16'hA000 | 16'(p * 128), 128, p + 1);
    // R7: stream across the array end
    arr_check("R7 stream read with wrap", 16'h71F0, DEPTH + 20);

    // R8: page wrap on write
    arr_write(16'h007C, 5, 9);
    arr_check("R8 page end region", 16'h0078, 9);
    arr_check("R8 page start", 16'h0000, 1);

    // R9: latch clear blocks writes
    set_latch(1'b0);
    arr_write(16'h0033, 3, 12);
    arr_check("R9 write without latch", 16'h0033, 3);

    // R10: each protect code against each quarter, latch clear and set
    for (int code = 0; code < 4; code++) begin
      set_latch(1'b0);
      stat_write(8'(code << 2));
      stat_check("R10 protect code readback", 1);
      arr_write(16'(10 + code), 1, 40 + code);
      arr_check("R10 latch clear under protect", 16'(10 + code), 1);
      set_latch(1'b1);
      for (int q = 0; q < 4; q++) begin
        arr_write(16'(q * DEPTH / 4 + 20 + code), 1, 20 + code * 4 + q);
        arr_check("R10 quarter write", 16'(q * DEPTH / 4 + 20 + code), 1);
      end
    end
    stat_write(8'h00);

    // R3: pause during a status read, with clock and select activity
    sel_on();
    xbyte(8'h05, rx);
    ser_hold_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < 3; i++) xbit(1'b1, r);
    ser_sel_n = 1'b1;
    wait_n(6);
    ser_sel_n = 1'b0;
    wait_n(6);
    ser_hold_n = 1'b1;
    wait_n(4);
    xbyte(8'h00, rx);
    check("R3 status after pause", rx, m_status());
    sel_off();

    // R3: pause in the middle of a write byte
    sel_on();
    xbyte(8'h02, rx);
    xbyte(8'h00, rx);
    xbyte(8'h40, rx);
    for (int i = 7; i >= 4; i--) xbit(1'(8'hC5 >> i), r);
    ser_hold_n = 1'b0;
    wait_n(4);
    for (int i = 0; i < 4; i++) xbit(1'b1, r);
    ser_hold_n = 1'b1;
    wait_n(4);
    for (int i = 3; i >= 0; i--) xbit(1'(8'hC5 >> i), r);
    sel_off();
    mdl[64] = 8'hC5;
    arr_check("R3 byte intact across pause", 16'h0040, 1);

    // R2: select abort in the middle of a latch-set command
    sel_on();
    for (int i = 0; i < 5; i++) xbit(1'b0, r);
    sel_off();
    set_latch(1'b0);
    sel_on();
    for (int i = 7; i >= 3; i--) xbit(1'(8'h06 >> i), r);
    sel_off();
    stat_check("R2 partial command dropped", 1);

    // R2: abort a read mid-byte, data-out returns high
    sel_on();
    xbyte(8'h03, rx);
    xbyte(8'h00, rx);
    xbyte(8'h00, rx);
    for (int i = 0; i < 3; i++) xbit(1'b0, r);
    sel_off();
    check("R2 dout high after abort", ser_dout, 1'b1);

    // R6: unknown command keeps data-out high and changes nothing
    sel_on();
    xbyte(8'h9F, rx);
    xbyte(8'h06, rx);
    check("R6 unknown command output", rx, 8'hFF);
    xbyte(8'h01, rx);
    check("R6 unknown command output again", rx, 8'hFF);
    sel_off();
    stat_check("R6 status unchanged", 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule